// File: doc/BRIEF.md
# Pixel Gray and Threshold Unit

This block is the arithmetic datapath of a single image-processing core. Each cycle it may take one 24-bit colour pixel, red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Depending on a 5-bit opcode, it either produces an 8-bit gray level or segments the pixel against two programmed thresholds. Every result lands in one output result register, and a one-cycle valid strobe marks each write.

Four 8-bit threshold registers hold the segmentation limits. One instruction loads them. The two 2-bit operand fields pick which registers act as the upper limit (operand A) and the lower limit (operand B). A start pulse arms the unit, and until then no pixel reaches the result register. Address generation and sequencing live in neighbouring logic.

Top module: `pix_gray_thresh`

## Requirements
- R1: After reset, `res_o` is 0, `res_vld_o` is 0, the unit is not armed and all four threshold registers hold 0.
- R2: Until a cycle with `start_i` high has been seen, a valid pixel never raises `res_vld_o` and leaves `res_o` unchanged. A pixel offered in the same cycle as `start_i` is also ignored.
- R3: Opcode 5'b00001 writes gray = (77·R + 151·G + 28·B) >> 8 to `res_o`, giving a range of 0 to 255.
- R4: Opcode 5'b00010 writes 255 when gray ≥ lower threshold, and 0 otherwise.
- R5: Opcode 5'b00011 writes the gray value when gray ≥ lower threshold, and 0 otherwise.
- R6: Opcode 5'b00100 writes 255 when lower ≤ gray ≤ upper (both limits inclusive), and 0 otherwise.
- R7: Opcode 5'b00101 writes the gray value when lower ≤ gray ≤ upper, and 0 otherwise.
- R8: Opcode 5'b00111 with a valid pixel loads `pix_i[7:0]` into the threshold register indexed by `sel_a_i`. It is accepted whether or not the unit is armed, and it neither raises `res_vld_o` nor changes `res_o`.
- R9: A result appears on `res_o`, with `res_vld_o` high, in the cycle after the accepting clock edge. `res_vld_o` stays high for exactly one cycle per pixel, and `res_o` holds its value while `res_vld_o` is low.
- R10: Any other opcode (for example 5'b00000 or 5'b00110) causes no write: `res_vld_o` stays low and `res_o` keeps its value.
- R11: The upper limit is the register indexed by `sel_a_i`, the lower limit is the register indexed by `sel_b_i`, and both may index the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arms the unit for processing |
| op_i | input | 5 | Operation code |
| sel_a_i | input | 2 | Upper-threshold register index, and write index for register loads |
| sel_b_i | input | 2 | Lower-threshold register index |
| pix_vld_i | input | 1 | Pixel input is valid this cycle |
| pix_i | input | 24 | Pixel, {R,G,B}, 8 bits each |
| res_o | output | 8 | Result register |
| res_vld_o | output | 1 | Result register was written |

## Verification
Gray conversion is tried with pure red, pure green and pure blue, which separates the three weights from one another. White and black confirm the range ends.

Gray pixels with equal channels give exact levels one below, on and one above each threshold. These tell apart inclusive from exclusive compares and the lower limit from the upper one, and they show whether the binary modes output 255 where the half modes output the gray level.

Moving both operand selects onto the same register turns the spectral window into a single level, which proves the two indexes are decoded independently. Unknown opcodes, register loads and pixels sent before start are all checked against a result left over from an earlier pixel, so a spurious write shows up.

// File: rtl/pix_gray_thresh.sv
module pix_gray_thresh #(
  parameter int PW = 8,
  parameter int NTHR = 4,
  parameter int OPW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [OPW-1:0]        op_i,
  input  logic [1:0]            sel_a_i,
  input  logic [1:0]            sel_b_i,
  input  logic                  pix_vld_i,
  input  logic [3*PW-1:0]       pix_i,
  output logic [PW-1:0]         res_o,
  output logic                  res_vld_o
);
  localparam int SW = 2*PW;
  localparam logic [PW-1:0] FULL = {PW{1'b1}};
  localparam logic [OPW-1:0] OP_GRAY = OPW'(1);
  localparam logic [OPW-1:0] OP_BIN  = OPW'(2);
  localparam logic [OPW-1:0] OP_HALF = OPW'(3);
  localparam logic [OPW-1:0] OP_BAND = OPW'(4);
  localparam logic [OPW-1:0] OP_HBND = OPW'(5);
  localparam logic [OPW-1:0] OP_WTHR = OPW'(7);

  logic [PW-1:0] thr_q [NTHR];
  logic          armed_q;
  logic [SW-1:0] wsum;
  logic [PW-1:0] gray, hi_t, lo_t, nxt;
  logic          ge_lo, le_hi, wr;

  assign wsum = SW'(pix_i[3*PW-1:2*PW]) * SW'(77)
              + SW'(pix_i[2*PW-1:PW])   * SW'(151)
              + SW'(pix_i[PW-1:0])      * SW'(28);
  assign gray  = wsum[SW-1:PW];
  assign hi_t  = thr_q[sel_a_i];
  assign lo_t  = thr_q[sel_b_i];
  assign ge_lo = gray >= lo_t;
  assign le_hi = gray <= hi_t;

  always_comb begin
    wr  = 1'b1;
    nxt = '0;
    unique case (op_i)
      OP_GRAY: nxt = gray;
      OP_BIN:  nxt = ge_lo ? FULL : '0;
      OP_HALF: nxt = ge_lo ? gray : '0;
      OP_BAND: nxt = (ge_lo && le_hi) ? FULL : '0;
      OP_HBND: nxt = (ge_lo && le_hi) ? gray : '0;
      default: wr  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      if (start_i) armed_q <= 1'b1;
      res_vld_o <= pix_vld_i && armed_q && wr;
      if (pix_vld_i && armed_q && wr) res_o <= nxt;
    end
  end

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rst_n) thr_q[i] <= '0;
      else if (pix_vld_i && op_i == OP_WTHR && sel_a_i == 2'(i))
        thr_q[i] <= pix_i[PW-1:0];
    end
  end
endmodule

module pix_gray_thresh_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic [4:0] op_i,
  input logic       pix_vld_i,
  input logic [7:0] res_o,
  input logic       res_vld_o
);
  // R2
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && !armed) |=> !res_vld_o);
  // R9
  vld_needs_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $past(pix_vld_i));
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> $stable(res_o));
  // R8
  thr_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && op_i == 5'd7) |=> !res_vld_o);
  // R10
  bad_op_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && (op_i == 5'd0 || op_i == 5'd6 || op_i > 5'd7)) |=> !res_vld_o);
  // R4
  bin_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && armed && op_i == 5'd2) |=> (res_o == 8'd0 || res_o == 8'd255));
  // R6
  band_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && armed && op_i == 5'd4) |=> (res_o == 8'd0 || res_o == 8'd255));
endmodule

bind pix_gray_thresh pix_gray_thresh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed_q), .op_i(op_i),
  .pix_vld_i(pix_vld_i), .res_o(res_o), .res_vld_o(res_vld_o)
);

// File: tb/pix_gray_thresh_tb.sv
`timescale 1ns/1ps
module pix_gray_thresh_tb;
  logic clk = 0, rst_n = 0, start_i = 0, pix_vld_i = 0;
  logic [4:0] op_i = 0;
  logic [1:0] sel_a_i = 0, sel_b_i = 0;
  logic [23:0] pix_i = 0;
  logic [7:0] res_o;
  logic res_vld_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pix_gray_thresh u_dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .pix_vld_i(pix_vld_i), .pix_i(pix_i),
    .res_o(res_o), .res_vld_o(res_vld_o));

  // {req, op, pix, expected}; thresholds: upper reg1=200, lower reg0=100
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {4'd3, 5'd1, 24'hFF0000, 8'd76},   // R3 red weight
    {4'd3, 5'd1, 24'h00FF00, 8'd150},  // R3 green weight
    {4'd3, 5'd1, 24'h0000FF, 8'd27},   // R3 blue weight
    {4'd3, 5'd1, 24'hFFFFFF, 8'd255},  // R3 top of range
    {4'd4, 5'd2, 24'h636363, 8'd0},    // R4 below lower
    {4'd4, 5'd2, 24'h646464, 8'd255},  // R4 on lower
    {4'd5, 5'd3, 24'h636363, 8'd0},    // R5 below lower
    {4'd5, 5'd3, 24'hC9C9C9, 8'd201},  // R5 above upper still passes
    {4'd6, 5'd4, 24'h646464, 8'd255},  // R6 on lower
    {4'd6, 5'd4, 24'hC8C8C8, 8'd255},  // R6 on upper
    {4'd6, 5'd4, 24'hC9C9C9, 8'd0},    // R6 above upper
    {4'd7, 5'd5, 24'hC8C8C8, 8'd200},  // R7 on upper
    {4'd7, 5'd5, 24'h636363, 8'd0},    // R7 below lower
    {4'd7, 5'd5, 24'h969696, 8'd150},  // R7 inside
    {4'd3, 5'd1, 24'h000000, 8'd0}     // R3 bottom of range
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] op, input logic [23:0] px,
                      input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    op_i = op; pix_i = px; sel_a_i = a; sel_b_i = b; pix_vld_i = 1;
    @(negedge clk);
    pix_vld_i = 0;
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic arm();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  initial begin
    reset_dut();
    chk("R1 res_o", {1'b0, res_o}, 9'd0);
    chk("R1 res_vld_o", {8'd0, res_vld_o}, 9'd0);
    send(5'd1, 24'hFFFFFF, 2'd1, 2'd0);
    chk("R2 vld before start", {8'd0, res_vld_o}, 9'd0);
    chk("R2 res before start", {1'b0, res_o}, 9'd0);
    send(5'd7, 24'h0000C8, 2'd1, 2'd0);
    chk("R8 write no vld", {8'd0, res_vld_o}, 9'd0);
    send(5'd7, 24'h000064, 2'd0, 2'd0);
    chk("R8 write res held", {1'b0, res_o}, 9'd0);
    @(negedge clk); start_i = 1; op_i = 5'd1; pix_i = 24'hFFFFFF; pix_vld_i = 1;
    @(negedge clk); start_i = 0; pix_vld_i = 0;
    chk("R2 same-cycle start", {8'd0, res_vld_o}, 9'd0);
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][36:32], VEC[i][31:8], 2'd1, 2'd0);
      chk($sformatf("R%0d vld vec %0d", VEC[i][40:37], i), {8'd0, res_vld_o}, 9'd1);
      chk($sformatf("R%0d value vec %0d", VEC[i][40:37], i), {1'b0, res_o}, {1'b0, VEC[i][7:0]});
    end
    send(5'd1, 24'h969696, 2'd1, 2'd0);
    @(negedge clk);
    chk("R9 strobe one cycle", {8'd0, res_vld_o}, 9'd0);
    chk("R9 value held", {1'b0, res_o}, 9'd150);
    send(5'd6, 24'hFFFFFF, 2'd1, 2'd0);
    chk("R10 op6 no vld", {8'd0, res_vld_o}, 9'd0);
    chk("R10 op6 res held", {1'b0, res_o}, 9'd150);
    send(5'd0, 24'hFFFFFF, 2'd1, 2'd0);
    chk("R10 op0 res held", {1'b0, res_o}, 9'd150);
    send(5'd7, 24'h000011, 2'd3, 2'd0);
    chk("R8 write after arm res held", {1'b0, res_o}, 9'd150);
    send(5'd2, 24'h969696, 2'd1, 2'd1);
    chk("R11 lower from sel_b", {1'b0, res_o}, 9'd0);
    send(5'd2, 24'h969696, 2'd1, 2'd0);
    chk("R11 lower back to reg0", {1'b0, res_o}, 9'd255);
    send(5'd4, 24'h646464, 2'd0, 2'd0);
    chk("R11 shared reg on level", {1'b0, res_o}, 9'd255);
    send(5'd4, 24'h656565, 2'd0, 2'd0);
    chk("R11 shared reg off level", {1'b0, res_o}, 9'd0);
    send(5'd2, 24'h121212, 2'd1, 2'd3);
    chk("R8 reg3 loaded", {1'b0, res_o}, 9'd255);
    reset_dut();
    chk("R1 res after reset", {1'b0, res_o}, 9'd0);
    send(5'd1, 24'hFFFFFF, 2'd1, 2'd0);
    chk("R1 disarmed after reset", {8'd0, res_vld_o}, 9'd0);
    arm();
    send(5'd3, 24'h000000, 2'd1, 2'd0);
    chk("R1 thresholds cleared", {8'd0, res_vld_o}, 9'd1);
    send(5'd4, 24'h010101, 2'd1, 2'd0);
    chk("R1 upper cleared", {1'b0, res_o}, 9'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule